// File: doc/BRIEF.md
# Crossbar Row Self-Test and Spare Remapper

This block checks every row of one crossbar array when asked, and steers later row accesses away from rows that failed. The array has a set of regular rows (256 by default) and a small pool of spare rows (4 by default). A test pass writes a full-width all-ones word into each row and reads it back. It then writes all zeros and reads again. Any difference between what was written and what came back marks the row as failing.

The pass checks the spare rows first, so a faulty spare is never handed out. The regular rows follow in ascending order. A failing regular row is marked in a bad-row bitmap and assigned to the lowest-numbered usable spare that is still free. When the spares run out, a repair-fail flag is raised and the remaining failing rows stay in the bitmap without a spare.

Between passes, a translation path turns a logical row number into the physical row to access. It answers one cycle after each request. A new pass can be started at any idle moment, for example periodically to pick up rows that have drifted. Each pass rebuilds the bitmap and the assignments from scratch.

Top module: `row_repair_top`

## Requirements
- R1: After reset, `busy`, `done`, `repair_fail`, `xlat_ack`, `arr_we` and `arr_re` are all low, and `map_bad` is low for every row.
- R2: A `start` pulse while idle begins a pass: `busy` goes high on the next cycle and stays high until the pass ends. `done` is then high for exactly one cycle with `busy` low. A `start` while busy has no effect.
- R3: A pass tests physical rows in this order: spares first (spare s sits at physical row ROWS+s, for example 256..259), then regular rows 0..ROWS-1. For each row, the pass writes all ones, reads, writes all zeros, and reads again. A read request (`arr_re`) always comes in the cycle right after the write to the same row, and read data is expected on `arr_rdata` one cycle after `arr_re`.
- R4: A row fails when either read differs from the pattern written. A failing regular row reads `map_bad`=1 at its index after the pass, and a passing row reads 0.
- R5: A spare that fails its own test is never assigned to any row.
- R6: Failing regular rows, taken in ascending row order, receive the usable spares in ascending spare order.
- R7: If more regular rows fail than there are usable spares, `repair_fail` is high after the pass. The rows left without a spare keep `map_bad`=1 and translate to themselves.
- R8: When idle, a request with `xlat_req`=1 gives `xlat_ack`=1 on the next cycle. `xlat_phys` is ROWS+s when the requested row is assigned to spare s, and otherwise the row number unchanged.
- R9: While a pass runs, `xlat_ack` stays low on the cycle after any request.
- R10: A new pass clears the previous bitmap, the spare assignments and `repair_fail` before it rebuilds them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test pass (used only when idle) |
| busy | output | 1 | Test pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| repair_fail | output | 1 | Last pass ran out of usable spares |
| arr_we | output | 1 | Array row write strobe |
| arr_re | output | 1 | Array row read strobe |
| arr_row | output | 9 | Physical row for the array access |
| arr_wdata | output | 16 | Pattern written to the row |
| arr_rdata | input | 16 | Row contents, valid one cycle after `arr_re` |
| xlat_req | input | 1 | Translation request |
| xlat_row | input | 8 | Logical row to translate |
| xlat_ack | output | 1 | Translation result valid |
| xlat_phys | output | 9 | Physical row for the requested logical row |
| map_row | input | 8 | Row index for the bad-row bitmap query |
| map_bad | output | 1 | Bitmap bit of `map_row` |

## Verification
The bench models the array with per-row stuck-at-one and stuck-at-zero bits. This lets it check that each polarity of fault is caught. A design that tested only one pattern would leave half of these rows looking healthy.

Faulty spares combined with several failing rows check the skip-and-ascend allocation. A design that ignored a spare's own result would translate a row onto a broken spare. A design with a wrong priority would swap spare numbers.

An overflow case checks that the surplus row stays bad and passes through untranslated, rather than reusing an occupied spare. A second clean pass then checks that stale entries are gone.

A request and a second `start` in mid-pass check that translation stays off while the test runs and that the pass is not restarted. A design that got this wrong would issue more than the expected number of writes or more than one `done`.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_CHECK = 2'd3
    } rr_state_e;

endpackage

// File: rtl/rr_spare_pick.sv
module rr_spare_pick #(
    parameter  int SPARES = 4,
    localparam int SIW    = (SPARES > 1) ? $clog2(SPARES) : 1
) (
    input  logic [SPARES-1:0] usable,
    input  logic [SPARES-1:0] taken,
    output logic              found,
    output logic [SIW-1:0]    pick
);

    // lowest free, usable spare wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int s = SPARES - 1; s >= 0; s--) begin
            if (usable[s] && !taken[s]) begin
                found = 1'b1;
                pick  = SIW'(s);
            end
        end
    end

endmodule

// File: rtl/rr_remap.sv
module rr_remap #(
    parameter  int ROWS   = 256,
    parameter  int SPARES = 4,
    localparam int AW     = $clog2(ROWS),
    localparam int PAW    = $clog2(ROWS + SPARES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic                       req,
    input  logic [AW-1:0]              row,
    input  logic [SPARES-1:0]          ent_valid,
    input  logic [SPARES-1:0][AW-1:0]  ent_row,
    output logic                       ack,
    output logic [PAW-1:0]             phys
);

    typedef struct packed {
        logic           ack;
        logic [PAW-1:0] phys;
    } remap_s;

    remap_s            r_d, r_q;
    logic [SPARES-1:0] hit;

    for (genvar s = 0; s < SPARES; s++) begin : g_cmp
        assign hit[s] = ent_valid[s] && (ent_row[s] == row);
    end

    always_comb begin
        r_d      = r_q;
        r_d.ack  = req && !busy;
        r_d.phys = PAW'(row);
        for (int s = 0; s < SPARES; s++) begin
            if (hit[s]) r_d.phys = PAW'(ROWS + s);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ack  = r_q.ack;
    assign phys = r_q.phys;

    // R8: a logical row is held by at most one spare
    a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R9: no translation answer while a pass is running
    a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack);

endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
    import rr_pkg::*;
#(
    parameter  int ROWS   = 256,
    parameter  int SPARES = 4,
    parameter  int DW     = 16,
    localparam int AW     = $clog2(ROWS),
    localparam int PAW    = $clog2(ROWS + SPARES),
    localparam int SIW    = (SPARES > 1) ? $clog2(SPARES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output logic                       busy,
    output logic                       done,
    output logic                       repair_fail,
    output logic                       arr_we,
    output logic                       arr_re,
    output logic [PAW-1:0]             arr_row,
    output logic [DW-1:0]              arr_wdata,
    input  logic [DW-1:0]              arr_rdata,
    output logic [SPARES-1:0]          ent_valid,
    output logic [SPARES-1:0][AW-1:0]  ent_row,
    input  logic [AW-1:0]              map_row,
    output logic                       map_bad
);

    localparam logic [PAW-1:0] LAST = PAW'(ROWS + SPARES - 1);

    typedef struct packed {
        rr_state_e                 st;
        logic [PAW-1:0]            idx;
        logic                      phase;   // 0: ones, 1: zeros
        logic                      fail;
        logic                      done;
        logic                      rfail;
        logic [SPARES-1:0]         sp_ok;
        logic [SPARES-1:0]         used;
        logic [SPARES-1:0][AW-1:0] map;
        logic [ROWS-1:0]           bad;
    } ctrl_s;

    ctrl_s          c_d, c_q;
    logic           is_spare;
    logic [SIW-1:0] sp_idx;
    logic [AW-1:0]  reg_row;
    logic [PAW-1:0] cur_phys;
    logic [DW-1:0]  pattern;
    logic           row_fail;
    logic           pick_found;
    logic [SIW-1:0] pick;

    assign is_spare = c_q.idx < PAW'(SPARES);
    assign sp_idx   = SIW'(c_q.idx);
    assign reg_row  = AW'(c_q.idx - PAW'(SPARES));
    assign cur_phys = is_spare ? (PAW'(ROWS) + c_q.idx) : PAW'(reg_row);
    assign pattern  = c_q.phase ? '0 : '1;
    assign row_fail = c_q.fail || (arr_rdata != pattern);

    rr_spare_pick #(.SPARES(SPARES)) i_pick (
        .usable (c_q.sp_ok),
        .taken  (c_q.used),
        .found  (pick_found),
        .pick   (pick)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st    = ST_WRITE;
                    c_d.idx   = '0;
                    c_d.phase = 1'b0;
                    c_d.fail  = 1'b0;
                    c_d.rfail = 1'b0;
                    c_d.sp_ok = '1;
                    c_d.used  = '0;
                    c_d.map   = '0;
                    c_d.bad   = '0;
                end
            end
            ST_WRITE: c_d.st = ST_READ;
            ST_READ:  c_d.st = ST_CHECK;
            ST_CHECK: begin
                if (!c_q.phase) begin
                    c_d.phase = 1'b1;
                    c_d.fail  = row_fail;
                    c_d.st    = ST_WRITE;
                end else begin
                    c_d.phase = 1'b0;
                    c_d.fail  = 1'b0;
                    if (row_fail) begin
                        if (is_spare) begin
                            c_d.sp_ok[sp_idx] = 1'b0;
                        end else begin
                            c_d.bad[reg_row] = 1'b1;
                            if (pick_found) begin
                                c_d.used[pick] = 1'b1;
                                c_d.map[pick]  = reg_row;
                            end else begin
                                c_d.rfail = 1'b1;
                            end
                        end
                    end
                    if (c_q.idx == LAST) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                        c_d.st  = ST_WRITE;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.st    <= ST_IDLE;
            c_q.sp_ok <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy        = (c_q.st != ST_IDLE);
    assign done        = c_q.done;
    assign repair_fail = c_q.rfail;
    assign arr_we      = (c_q.st == ST_WRITE);
    assign arr_re      = (c_q.st == ST_READ);
    assign arr_row     = cur_phys;
    assign arr_wdata   = pattern;
    assign ent_valid   = c_q.used;
    assign ent_row     = c_q.map;
    assign map_bad     = c_q.bad[map_row];

    // R2: completion strobe lasts one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: every read is preceded by a write to the same row
    a_r3_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        arr_re |-> ($past(arr_we) && $stable(arr_row)));

    // R5: an assigned spare passed its own test
    for (genvar s = 0; s < SPARES; s++) begin : g_chk
        a_r5_spare_usable: assert property (@(posedge clk) disable iff (!rst_n)
            c_q.used[s] |-> c_q.sp_ok[s]);
    end

    // R7: repair failure only once no usable spare remains free
    a_r7_fail_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        repair_fail |-> ((c_q.sp_ok & ~c_q.used) == '0));

endmodule

// File: rtl/row_repair_top.sv
module row_repair_top #(
    parameter  int ROWS   = 256,
    parameter  int SPARES = 4,
    parameter  int DW     = 16,
    localparam int AW     = $clog2(ROWS),
    localparam int PAW    = $clog2(ROWS + SPARES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic           repair_fail,
    output logic           arr_we,
    output logic           arr_re,
    output logic [PAW-1:0] arr_row,
    output logic [DW-1:0]  arr_wdata,
    input  logic [DW-1:0]  arr_rdata,
    input  logic           xlat_req,
    input  logic [AW-1:0]  xlat_row,
    output logic           xlat_ack,
    output logic [PAW-1:0] xlat_phys,
    input  logic [AW-1:0]  map_row,
    output logic           map_bad
);

    logic [SPARES-1:0]         ent_valid;
    logic [SPARES-1:0][AW-1:0] ent_row;
    logic                      busy_w;

    rr_ctrl #(.ROWS(ROWS), .SPARES(SPARES), .DW(DW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .busy        (busy_w),
        .done        (done),
        .repair_fail (repair_fail),
        .arr_we      (arr_we),
        .arr_re      (arr_re),
        .arr_row     (arr_row),
        .arr_wdata   (arr_wdata),
        .arr_rdata   (arr_rdata),
        .ent_valid   (ent_valid),
        .ent_row     (ent_row),
        .map_row     (map_row),
        .map_bad     (map_bad)
    );

    rr_remap #(.ROWS(ROWS), .SPARES(SPARES)) i_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy_w),
        .req       (xlat_req),
        .row       (xlat_row),
        .ent_valid (ent_valid),
        .ent_row   (ent_row),
        .ack       (xlat_ack),
        .phys      (xlat_phys)
    );

    assign busy = busy_w;

endmodule

// File: tb/test_row_repair_top.sv
`timescale 1ns/1ps
module test_row_repair_top;

    localparam int ROWS = 256;
    localparam int SP   = 4;
    localparam int NR   = ROWS + SP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, repair_fail;
    logic        arr_we, arr_re;
    logic [8:0]  arr_row;
    logic [15:0] arr_wdata;
    logic [15:0] arr_rdata;
    logic        xlat_req = 1'b0;
    logic [7:0]  xlat_row = '0;
    logic        xlat_ack;
    logic [8:0]  xlat_phys;
    logic [7:0]  map_row = '0;
    logic        map_bad;

    int total = 0;
    int bad   = 0;
    int n_wr  = 0;
    int n_seq = 0;
    int n_done = 0;

    logic [15:0] mem [NR];
    logic [15:0] st1 [NR];
    logic [15:0] st0 [NR];

    always #2.5 clk = ~clk;

    row_repair_top i_row_repair_top (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .repair_fail(repair_fail), .arr_we(arr_we), .arr_re(arr_re),
        .arr_row(arr_row), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .xlat_req(xlat_req), .xlat_row(xlat_row), .xlat_ack(xlat_ack),
        .xlat_phys(xlat_phys), .map_row(map_row), .map_bad(map_bad)
    );

    // array model: registered read with stuck bits applied
    always_ff @(posedge clk) begin
        if (arr_we) mem[arr_row] <= arr_wdata;
        if (arr_re) arr_rdata <= (mem[arr_row] & ~st0[arr_row]) | st1[arr_row];
    end

    // access order monitor (R3)
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            int i;
            logic [8:0]  ep;
            logic [15:0] ed;
            i  = n_wr / 2;
            ep = (i < SP) ? 9'(ROWS + i) : 9'(i - SP);
            ed = (n_wr % 2 == 0) ? 16'hFFFF : 16'h0000;
            if (arr_row != ep || arr_wdata != ed) n_seq++;
            n_wr++;
        end
        if (rst_n && done) n_done++;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clear_faults();
        for (int r = 0; r < NR; r++) begin
            st1[r] = '0;
            st0[r] = '0;
        end
    endtask

    task automatic run_pass(input bit poke_busy);
        int cyc;
        n_wr = 0; n_seq = 0; n_done = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            xlat_req = 1'b1; xlat_row = 8'd3; start = 1'b1;
            @(negedge clk);
            chk(xlat_ack == 1'b0, "R9 no ack while busy", int'(xlat_ack), 0);
            xlat_req = 1'b0; start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1 && busy == 1'b0, "R2 done with busy low", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && n_done == 1, "R2 single done pulse", n_done, 1);
        chk(n_seq == 0 && n_wr == 2 * NR, "R3 write order and count", n_wr, 2 * NR);
    endtask

    task automatic xlat(input int r, input int exp, input string rq);
        @(negedge clk) begin xlat_req = 1'b1; xlat_row = 8'(r); end
        @(negedge clk);
        chk(xlat_ack == 1'b1 && xlat_phys == 9'(exp), rq, int'(xlat_phys), exp);
        xlat_req = 1'b0;
    endtask

    task automatic mapq(input int r, input bit exp, input string rq);
        map_row = 8'(r);
        #0.1;
        chk(map_bad == exp, rq, int'(map_bad), int'(exp));
    endtask

    task automatic t_reset();
        chk(!busy && !done && !repair_fail && !arr_we && !arr_re && !xlat_ack,
            "R1 outputs idle", int'({busy, done, repair_fail, arr_we, arr_re, xlat_ack}), 0);
        mapq(0, 1'b0, "R1 map clear row0");
        mapq(255, 1'b0, "R1 map clear row255");
    endtask

    task automatic t_clean();
        clear_faults();
        run_pass(1'b0);
        chk(repair_fail == 1'b0, "R7 no fail on clean array", int'(repair_fail), 0);
        xlat(0, 0, "R8 passthrough row0");
        xlat(200, 200, "R8 passthrough row200");
        mapq(10, 1'b0, "R4 clean row good");
    endtask

    task automatic t_two_faults();
        clear_faults();
        st1[10]  = 16'h0001;   // caught by the zeros pattern
        st0[200] = 16'h8000;   // caught by the ones pattern
        run_pass(1'b0);
        mapq(10, 1'b1, "R4 stuck-one row bad");
        mapq(200, 1'b1, "R4 stuck-zero row bad");
        mapq(11, 1'b0, "R4 neighbour row good");
        xlat(10, 256, "R6 first failure to spare0");
        xlat(200, 257, "R6 second failure to spare1");
        xlat(11, 11, "R8 good row passthrough");
    endtask

    task automatic t_bad_spare();
        clear_faults();
        st0[257] = 16'h0010;   // spare 1 broken
        st1[5] = 16'h0100;
        st0[6] = 16'h0002;
        st1[7] = 16'h4000;
        run_pass(1'b0);
        xlat(5, 256, "R6 row5 to spare0");
        xlat(6, 258, "R5 row6 skips broken spare1");
        xlat(7, 259, "R6 row7 to spare3");
        chk(repair_fail == 1'b0, "R5 three usable spares suffice", int'(repair_fail), 0);
    endtask

    task automatic t_overflow();
        clear_faults();
        st1[256] = 16'h0001;   // spare 0 broken
        for (int r = 1; r <= 4; r++) st0[r] = 16'h0004;
        run_pass(1'b0);
        chk(repair_fail == 1'b1, "R7 overflow flagged", int'(repair_fail), 1);
        xlat(1, 257, "R6 row1 to spare1");
        xlat(3, 259, "R6 row3 to spare3");
        xlat(4, 4, "R7 unrepaired row passthrough");
        mapq(4, 1'b1, "R7 unrepaired row bad");
    endtask

    task automatic t_rerun();
        clear_faults();
        run_pass(1'b1);
        chk(repair_fail == 1'b0, "R10 fail flag cleared", int'(repair_fail), 0);
        mapq(4, 1'b0, "R10 map cleared");
        xlat(1, 1, "R10 old mapping gone");
    endtask

    initial begin
        clear_faults();
        for (int r = 0; r < NR; r++) mem[r] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean();
        t_two_faults();
        t_bad_spare();
        t_overflow();
        t_rerun();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule